// File: doc/BRIEF.md
# Circular Reorder Buffer with Multi-Bus Writeback

This block keeps the program order of in-flight instructions in an out-of-order core. Each cycle it accepts a group of dispatched instructions. For each one it records the destination physical register, the physical register that the destination was mapped to before, and whether the instruction is a branch or a store. It returns a ring tag for every accepted slot. Execution units later return results on a set of common data buses, each carrying a tag, a value and a mispredict flag. The buffer marks the tagged entry complete and keeps the value.

Every cycle the oldest entries that are complete leave the buffer in program order. The commit port reports the destination, the value and the store flag of each one. It also reports the old physical register, which goes back to the rename free list. When a committing branch carries a mispredict flag, the branch itself retires and every younger entry is discarded. A one-cycle flush pulse tells the front end to restart.

Two counters support performance tuning. One counts the cycles in which dispatch waited for space. The other sums the number of busy buses over time.

Top module: `rob_ring`

## Requirements
- R1: After reset the buffer is empty. `full` is 0, `flush` is 0, `cm_valid` is 0, both counters read 0, and an empty dispatch group sees `disp_ready`=1.
- R2: A dispatch group is taken whole or not at all. `disp_ready` is 1 when the number of set `disp_valid` bits is no more than the number of free entries and no flush is under way. Valid slots get consecutive tags starting at the tail, lowest slot first. `disp_tag` lane i sits at bits [i*IW +: IW].
- R3: `full` is 1 exactly when all NR entries are occupied. Tags wrap from NR-1 back to 0 as the ring is reused.
- R4: A valid bus whose tag names an occupied entry marks that entry complete and stores its value and mispredict flag. Dispatch into an entry clears any earlier completion.
- R5: Each cycle up to NB entries commit, oldest first. Commit stops at the first entry that is not complete. `cm_valid` bit k means the k-th oldest entry retires, so the set bits always form a run from bit 0.
- R6: Commit lane k shows the retiring entry's destination register, its old physical register (released), its value, and its store flag.
- R7: When a committing entry is a branch whose mispredict flag is set, it is the last lane to commit. `flush` is 1 in that cycle, dispatch is refused, and the buffer is empty afterwards. The next allocated tag is the one just past the branch.
- R8: A mispredict flag on an entry that is not a branch has no effect on commit or flush.
- R9: `stall_cycles` increases by one in every cycle in which a non-empty dispatch group is refused for lack of space.
- R10: `bus_busy` gives the number of buses with `wb_valid` set in the current cycle. `bus_util_total` adds that number each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | NW | Per-slot dispatch valid |
| disp_dst | input | NW*PW | Per-slot destination physical register |
| disp_old | input | NW*PW | Per-slot previous mapping of the destination |
| disp_br | input | NW | Per-slot branch flag |
| disp_st | input | NW | Per-slot store flag |
| disp_ready | output | 1 | Group accepted this cycle |
| disp_tag | output | NW*IW | Tag given to each slot |
| wb_valid | input | NB | Per-bus result valid |
| wb_tag | input | NB*IW | Per-bus entry tag |
| wb_value | input | NB*DW | Per-bus result value |
| wb_mis | input | NB | Per-bus mispredict flag |
| cm_valid | output | NB | Per-lane commit valid, oldest in lane 0 |
| cm_dst | output | NB*PW | Committed destination register |
| cm_old | output | NB*PW | Released old physical register |
| cm_value | output | NB*DW | Committed value |
| cm_store | output | NB | Committed store flag |
| flush | output | 1 | Mispredicted branch retires this cycle |
| full | output | 1 | All entries occupied |
| bus_busy | output | BW | Buses in use this cycle |
| stall_cycles | output | CW | Full-stall cycle count |
| bus_util_total | output | CW | Accumulated bus use |

## Verification
A wrong head or tail pointer shows at the ports within a cycle. Tags come out shifted on the next dispatch, `full` rises at the wrong occupancy, or commit lanes report registers from the wrong entries. A stale completion flag shows up as a retire one cycle after the entry is dispatched again, before its result arrives. A broken flush shows in the tag given to the first dispatch after the mispredicted branch. The bench checks tags, occupancy, commit lanes and both counters at the cycle each of them changes, so a fault appears within one or two cycles of the stimulus that exposes it.

// File: rtl/rob_ring_pkg.sv
`timescale 1ns/1ps
// Shared types for the reorder ring.
// Assumes nothing beyond being compiled before the modules that import it.
package rob_ring_pkg;
    // Per-entry status bits kept beside the register fields
    typedef struct packed {
        logic done;
        logic is_br;
        logic is_st;
        logic mispred;
    } ent_flags_t;
endpackage

// File: rtl/rob_alloc.sv
`timescale 1ns/1ps
// Dispatch allocator: packs the valid slots of a group onto consecutive
// offsets from the tail and decides whether the whole group fits.
// Assumes NW <= 2**AW - 1 and that free_slots is current-cycle space.
module rob_alloc #(
    parameter int NW = 4,
    parameter int AW = 5
) (
    input  logic [NW-1:0]    disp_valid,
    input  logic [AW-1:0]    free_slots,
    input  logic             flush,
    output logic [NW*AW-1:0] offs,
    output logic [AW-1:0]    n_alloc,
    output logic             ready,
    output logic             blocked
);
    // Prefix count of valid slots gives each slot its offset
    always_comb begin
        logic [AW-1:0] run;
        run = '0;
        offs = '0;
        for (int i = 0; i < NW; i++) begin
            offs[i*AW +: AW] = run;
            run = run + AW'(disp_valid[i]);
        end
        n_alloc = run;
        blocked = (run != '0) && (run > free_slots);
        ready   = !flush && !blocked;
    end
endmodule

// File: rtl/rob_retire.sv
`timescale 1ns/1ps
// Retire scan: walks the NB oldest entries and takes the leading run of
// completed ones, ending after a mispredicted branch.
// Assumes NB <= NR and that window lane 0 is the head entry.
module rob_retire #(
    parameter int NB = 4,
    parameter int AW = 5
) (
    input  logic [AW-1:0] occ,
    input  logic [NB-1:0] win_done,
    input  logic [NB-1:0] win_br,
    input  logic [NB-1:0] win_mis,
    output logic [NB-1:0] take,
    output logic [AW-1:0] n_ret,
    output logic          flush
);
    // In-order scan with early stop
    always_comb begin
        logic go;
        go = 1'b1;
        take = '0;
        n_ret = '0;
        flush = 1'b0;
        for (int k = 0; k < NB; k++) begin
            if (go && (AW'(k) < occ) && win_done[k]) begin
                take[k] = 1'b1;
                n_ret = n_ret + AW'(1);
                if (win_br[k] && win_mis[k]) begin
                    flush = 1'b1;
                    go = 1'b0;
                end
            end else begin
                go = 1'b0;
            end
        end
    end
endmodule

// File: rtl/rob_stats.sv
`timescale 1ns/1ps
// Performance counters: full-stall cycles and common data bus use.
// Assumes counters may wrap at 2**CW.
module rob_stats #(
    parameter int NB = 4,
    parameter int CW = 32,
    parameter int BW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          blocked,
    input  logic [NB-1:0] wb_valid,
    output logic [BW-1:0] bus_busy,
    output logic [CW-1:0] stall_cycles,
    output logic [CW-1:0] bus_util_total
);
    // Count buses carrying data this cycle
    always_comb begin
        bus_busy = '0;
        for (int b = 0; b < NB; b++) bus_busy = bus_busy + BW'(wb_valid[b]);
    end

    // Accumulate stall cycles and bus use
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_cycles   <= '0;
            bus_util_total <= '0;
        end else begin
            if (blocked) stall_cycles <= stall_cycles + CW'(1);
            bus_util_total <= bus_util_total + CW'(bus_busy);
        end
    end
endmodule

// File: rtl/rob_ring.sv
`timescale 1ns/1ps
// Circular reorder buffer. Allocates tags in program order and captures
// results from NB buses. Retires up to NB completed entries per cycle and
// flushes younger entries behind a mispredicted branch.
// Assumes NR is a power of two, NW <= NR and NB <= NR.
module rob_ring
    import rob_ring_pkg::*;
#(
    parameter int NR = 16,
    parameter int NB = 4,
    parameter int NW = 4,
    parameter int PW = 5,
    parameter int DW = 32,
    parameter int CW = 32,
    localparam int IW = $clog2(NR),
    localparam int AW = IW + 1,
    localparam int BW = $clog2(NB + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NW-1:0]    disp_valid,
    input  logic [NW*PW-1:0] disp_dst,
    input  logic [NW*PW-1:0] disp_old,
    input  logic [NW-1:0]    disp_br,
    input  logic [NW-1:0]    disp_st,
    output logic             disp_ready,
    output logic [NW*IW-1:0] disp_tag,
    input  logic [NB-1:0]    wb_valid,
    input  logic [NB*IW-1:0] wb_tag,
    input  logic [NB*DW-1:0] wb_value,
    input  logic [NB-1:0]    wb_mis,
    output logic [NB-1:0]    cm_valid,
    output logic [NB*PW-1:0] cm_dst,
    output logic [NB*PW-1:0] cm_old,
    output logic [NB*DW-1:0] cm_value,
    output logic [NB-1:0]    cm_store,
    output logic             flush,
    output logic             full,
    output logic [BW-1:0]    bus_busy,
    output logic [CW-1:0]    stall_cycles,
    output logic [CW-1:0]    bus_util_total
);
    logic [AW-1:0]    head_q, tail_q, occ, free_slots, n_alloc, n_ret;
    logic [IW-1:0]    head_idx, tail_idx;
    logic [NW*AW-1:0] slot_off;
    logic [IW-1:0]    slot_idx [NW];
    logic [IW-1:0]    win_idx  [NB];
    logic [NB-1:0]    win_done, win_br, win_mis, wb_live;
    logic             blk_full;

    ent_flags_t       flg_q [NR];
    logic [PW-1:0]    dst_q [NR];
    logic [PW-1:0]    old_q [NR];
    logic [DW-1:0]    val_q [NR];

    assign head_idx   = head_q[IW-1:0];
    assign tail_idx   = tail_q[IW-1:0];
    assign occ        = tail_q - head_q;
    assign free_slots = AW'(NR) - occ;
    assign full       = (occ == AW'(NR));

    rob_alloc #(.NW(NW), .AW(AW)) u_alloc (
        .disp_valid(disp_valid), .free_slots(free_slots), .flush(flush),
        .offs(slot_off), .n_alloc(n_alloc), .ready(disp_ready),
        .blocked(blk_full)
    );

    rob_retire #(.NB(NB), .AW(AW)) u_retire (
        .occ(occ), .win_done(win_done), .win_br(win_br), .win_mis(win_mis),
        .take(cm_valid), .n_ret(n_ret), .flush(flush)
    );

    rob_stats #(.NB(NB), .CW(CW), .BW(BW)) u_stats (
        .clk(clk), .rst_n(rst_n), .blocked(blk_full), .wb_valid(wb_valid),
        .bus_busy(bus_busy), .stall_cycles(stall_cycles),
        .bus_util_total(bus_util_total)
    );

    // Slot tags: tail plus packed offset, wrapping around the ring
    for (genvar i = 0; i < NW; i++) begin : g_slot
        assign slot_idx[i] = tail_idx + slot_off[i*AW +: IW];
        assign disp_tag[i*IW +: IW] = slot_idx[i];
    end

    // Retire window: the NB oldest entries and their commit fields
    for (genvar k = 0; k < NB; k++) begin : g_win
        assign win_idx[k]  = head_idx + IW'(k);
        assign win_done[k] = flg_q[win_idx[k]].done;
        assign win_br[k]   = flg_q[win_idx[k]].is_br;
        assign win_mis[k]  = flg_q[win_idx[k]].mispred;
        assign cm_store[k] = flg_q[win_idx[k]].is_st;
        assign cm_dst[k*PW +: PW]   = dst_q[win_idx[k]];
        assign cm_old[k*PW +: PW]   = old_q[win_idx[k]];
        assign cm_value[k*DW +: DW] = val_q[win_idx[k]];
    end

    // Bus results count only when their tag names an occupied entry
    for (genvar b = 0; b < NB; b++) begin : g_bus
        logic [IW-1:0] off;
        assign off        = wb_tag[b*IW +: IW] - head_idx;
        assign wb_live[b] = wb_valid[b] && ({1'b0, off} < occ);
    end

    // Head advances by retired count; tail follows dispatch or flush
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            head_q <= head_q + n_ret;
            if (flush)           tail_q <= head_q + n_ret;
            else if (disp_ready) tail_q <= tail_q + n_alloc;
        end
    end

    // Status flags: completion from buses, fresh state on dispatch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < NR; e++) flg_q[e] <= '0;
        end else begin
            for (int b = 0; b < NB; b++) begin
                if (wb_live[b]) begin
                    flg_q[wb_tag[b*IW +: IW]].done    <= 1'b1;
                    flg_q[wb_tag[b*IW +: IW]].mispred <= wb_mis[b];
                end
            end
            if (disp_ready) begin
                for (int i = 0; i < NW; i++) begin
                    if (disp_valid[i]) begin
                        flg_q[slot_idx[i]] <= '{done: 1'b0, is_br: disp_br[i],
                                                is_st: disp_st[i], mispred: 1'b0};
                    end
                end
            end
        end
    end

    // Register fields and result values; no reset needed
    always_ff @(posedge clk) begin
        for (int b = 0; b < NB; b++) begin
            if (wb_live[b]) val_q[wb_tag[b*IW +: IW]] <= wb_value[b*DW +: DW];
        end
        if (disp_ready) begin
            for (int i = 0; i < NW; i++) begin
                if (disp_valid[i]) begin
                    dst_q[slot_idx[i]] <= disp_dst[i*PW +: PW];
                    old_q[slot_idx[i]] <= disp_old[i*PW +: PW];
                end
            end
        end
    end
endmodule

// File: rtl/rob_ring_chk.sv
`timescale 1ns/1ps
// Property checker for rob_ring, attached with bind.
// Assumes it sees the top's ports plus its occupancy count.
module rob_ring_chk #(
    parameter int NR = 16,
    parameter int NB = 4,
    parameter int NW = 4,
    parameter int CW = 32,
    localparam int AW = $clog2(NR) + 1,
    localparam int BW = $clog2(NB + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NW-1:0] disp_valid,
    input logic          disp_ready,
    input logic          full,
    input logic          flush,
    input logic [NB-1:0] cm_valid,
    input logic [BW-1:0] bus_busy,
    input logic [CW-1:0] stall_cycles,
    input logic [CW-1:0] bus_util_total,
    input logic [AW-1:0] occ
);
    logic [NB-1:0] cm_next;
    assign cm_next = cm_valid + NB'(1);

    // R3: occupancy never exceeds the ring size
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= AW'(NR));

    // R2: a full ring refuses any non-empty group
    a_r2_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (full && disp_valid != '0) |-> !disp_ready);

    // R5: commit lanes form a run from lane 0
    a_r5_commit_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_valid & cm_next) == '0);

    // R7: the ring is empty the cycle after a flush
    a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (occ == '0));

    // R9: a refused group for lack of space bumps the stall count
    a_r9_stall_step: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid != '0 && !disp_ready && !flush)
        |=> stall_cycles == $past(stall_cycles) + CW'(1));

    // R10: the use total grows by last cycle's busy count
    a_r10_util_sum: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> bus_util_total == $past(bus_util_total) + CW'($past(bus_busy)));
endmodule

bind rob_ring rob_ring_chk #(.NR(NR), .NB(NB), .NW(NW), .CW(CW)) u_rob_ring_chk (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .full(full), .flush(flush), .cm_valid(cm_valid), .bus_busy(bus_busy),
    .stall_cycles(stall_cycles), .bus_util_total(bus_util_total), .occ(occ)
);

// File: tb/test_rob_ring.sv
`timescale 1ns/1ps
// Self-checking bench for rob_ring with default parameters.
module test_rob_ring;
    localparam int NR = 16, NB = 4, NW = 4, PW = 5, DW = 32, CW = 32;
    localparam int IW = 4, BW = 3;

    logic clk = 1'b0;
    logic rst_n;
    logic [NW-1:0] disp_valid, disp_br, disp_st;
    logic [NW*PW-1:0] disp_dst, disp_old;
    logic disp_ready;
    logic [NW*IW-1:0] disp_tag;
    logic [NB-1:0] wb_valid, wb_mis;
    logic [NB*IW-1:0] wb_tag;
    logic [NB*DW-1:0] wb_value;
    logic [NB-1:0] cm_valid, cm_store;
    logic [NB*PW-1:0] cm_dst, cm_old;
    logic [NB*DW-1:0] cm_value;
    logic flush, full;
    logic [BW-1:0] bus_busy;
    logic [CW-1:0] stall_cycles, bus_util_total;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rob_ring i_rob_ring (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_dst(disp_dst),
        .disp_old(disp_old), .disp_br(disp_br), .disp_st(disp_st),
        .disp_ready(disp_ready), .disp_tag(disp_tag), .wb_valid(wb_valid),
        .wb_tag(wb_tag), .wb_value(wb_value), .wb_mis(wb_mis),
        .cm_valid(cm_valid), .cm_dst(cm_dst), .cm_old(cm_old),
        .cm_value(cm_value), .cm_store(cm_store), .flush(flush), .full(full),
        .bus_busy(bus_busy), .stall_cycles(stall_cycles),
        .bus_util_total(bus_util_total)
    );

    // Completion mask {bit0 = oldest} and expected commit lanes
    localparam logic [7:0] VEC [8] = '{
        {4'b0000, 4'b0000}, {4'b0001, 4'b0001}, {4'b0011, 4'b0011},
        {4'b0111, 4'b0111}, {4'b1111, 4'b1111}, {4'b1110, 4'b0000},
        {4'b1011, 4'b0011}, {4'b0101, 4'b0001}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_disp();
        disp_valid = '0; disp_br = '0; disp_st = '0; disp_dst = '0; disp_old = '0;
    endtask

    task automatic clear_wb();
        wb_valid = '0; wb_mis = '0; wb_tag = '0; wb_value = '0;
    endtask

    task automatic drive_disp(input logic [3:0] v, input logic [3:0] br,
                              input logic [3:0] st, input int base);
        disp_valid = v; disp_br = br; disp_st = st;
        for (int i = 0; i < NW; i++) begin
            disp_dst[i*PW +: PW] = PW'(base + i);
            disp_old[i*PW +: PW] = PW'(base + i + 16);
        end
    endtask

    task automatic drive_wb(input int b, input int tag, input int val, input logic mis);
        wb_valid[b] = 1'b1;
        wb_tag[b*IW +: IW] = IW'(tag);
        wb_value[b*DW +: DW] = DW'(val);
        wb_mis[b] = mis;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        clear_disp();
        clear_wb();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        #1;
        chk("R1 full", full, 0);
        chk("R1 flush", flush, 0);
        chk("R1 cm_valid", cm_valid, 0);
        chk("R1 stall", stall_cycles, 0);
        chk("R1 util", bus_util_total, 0);
        chk("R1 ready", disp_ready, 1);

        // R5 and R10: table of completion patterns
        for (int v = 0; v < 8; v++) begin
            do_reset();
            @(negedge clk); drive_disp(4'b1111, 4'b0000, 4'b0000, 0);
            @(negedge clk); clear_disp();
            for (int b = 0; b < NB; b++)
                if (VEC[v][4 + b]) drive_wb(b, b, 100 + b, 1'b0);
            #1;
            chk("R10 bus_busy", bus_busy, $countones(VEC[v][7:4]));
            @(negedge clk); clear_wb();
            chk("R5 commit run", cm_valid, VEC[v][3:0]);
        end

        // R2: packed tags
        do_reset();
        @(negedge clk); drive_disp(4'b1010, 4'b0000, 4'b0000, 0); #1;
        chk("R2 tag slot1", disp_tag[1*IW +: IW], 0);
        chk("R2 tag slot3", disp_tag[3*IW +: IW], 1);
        @(negedge clk); drive_disp(4'b0111, 4'b0000, 4'b0000, 0); #1;
        chk("R2 tags 2-slot", disp_tag[3*IW-1:0], 12'h432);
        @(negedge clk); clear_disp();

        // R2, R3, R9: fill, refuse, wrap
        do_reset();
        @(negedge clk); drive_disp(4'b1111, 0, 0, 0);
        @(negedge clk); drive_disp(4'b1111, 0, 0, 4);
        @(negedge clk); drive_disp(4'b1111, 0, 0, 8);
        @(negedge clk); drive_disp(4'b0011, 0, 0, 12);
        @(negedge clk); drive_disp(4'b1111, 0, 0, 0); #1;
        chk("R2 group refused", disp_ready, 0);
        repeat (3) @(negedge clk);
        chk("R9 stall count", stall_cycles, 3);
        drive_disp(4'b0011, 0, 0, 14); #1;
        chk("R2 fitting group", disp_ready, 1);
        @(negedge clk); clear_disp();
        chk("R3 full", full, 1);
        drive_disp(4'b0001, 0, 0, 0); #1;
        chk("R2 full refuses", disp_ready, 0);
        @(negedge clk); clear_disp();
        chk("R9 stall count 2", stall_cycles, 4);
        for (int b = 0; b < NB; b++) drive_wb(b, b, 200 + b, 1'b0);
        @(negedge clk); clear_wb();
        chk("R5 commit four", cm_valid, 4'b1111);
        chk("R6 old reg lane0", cm_old[0 +: PW], 16);
        chk("R6 dst lane3", cm_dst[3*PW +: PW], 3);
        @(negedge clk);
        chk("R3 not full", full, 0);
        drive_disp(4'b1111, 0, 0, 20); #1;
        chk("R3 wrapped tags", disp_tag, 16'h3210);
        @(negedge clk); clear_disp();
        chk("R3 full again", full, 1);

        // R5, R6: two commit cycles, out-of-order completion
        do_reset();
        @(negedge clk); drive_disp(4'b1111, 4'b0000, 4'b0100, 1);
        @(negedge clk); drive_disp(4'b1111, 4'b0000, 4'b0000, 10);
        @(negedge clk); clear_disp();
        for (int b = 0; b < NB; b++) drive_wb(b, 4 + b, 40 + b, 1'b0);
        @(negedge clk); clear_wb();
        chk("R5 oldest pending", cm_valid, 0);
        for (int b = 0; b < NB; b++) drive_wb(b, b, 160 + b, 1'b0);
        @(negedge clk); clear_wb();
        chk("R5 first four", cm_valid, 4'b1111);
        chk("R6 value lane0", cm_value[0 +: DW], 160);
        chk("R6 store flags", cm_store, 4'b0100);
        chk("R6 old lane2", cm_old[2*PW +: PW], 19);
        @(negedge clk);
        chk("R5 next four", cm_valid, 4'b1111);
        chk("R5 dst lane0", cm_dst[0 +: PW], 10);
        chk("R6 value lane3", cm_value[3*DW +: DW], 43);
        @(negedge clk);
        chk("R5 drained", cm_valid, 0);

        // R7, R4: mispredicted branch flush
        do_reset();
        @(negedge clk); drive_disp(4'b1111, 4'b0010, 4'b0000, 0);
        @(negedge clk); clear_disp();
        drive_wb(0, 0, 1, 1'b0); drive_wb(1, 1, 2, 1'b1);
        drive_wb(2, 2, 3, 1'b0); drive_wb(3, 3, 4, 1'b0);
        @(negedge clk); clear_wb();
        drive_disp(4'b0001, 0, 0, 9); #1;
        chk("R7 lanes to branch", cm_valid, 4'b0011);
        chk("R7 flush pulse", flush, 1);
        chk("R7 dispatch held", disp_ready, 0);
        @(negedge clk); #1;
        chk("R7 flush ends", flush, 0);
        chk("R7 tag past branch", disp_tag[0 +: IW], 2);
        @(negedge clk); clear_disp();
        chk("R4 cleared on redispatch", cm_valid, 0);

        // R8, R10: mispredict flag on a plain entry
        do_reset();
        @(negedge clk); drive_disp(4'b1111, 4'b0000, 4'b0000, 0);
        @(negedge clk); clear_disp();
        for (int b = 0; b < NB; b++) drive_wb(b, b, 7, b == 1);
        #1;
        chk("R10 all buses busy", bus_busy, 4);
        @(negedge clk); clear_wb();
        chk("R8 all commit", cm_valid, 4'b1111);
        chk("R8 no flush", flush, 0);
        chk("R10 util total", bus_util_total, 4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule